// File: doc/BRIEF.md
# PLL and Peripheral Bus Clock Frequency Calculator

This block works out three clock frequencies as integer hertz values: the reference input clock, the output of the high-speed PLL, and the peripheral bus clock. It reads them from the strap inputs, the PLL configuration word, the clock-select word and a chip-variant input. The configuration words come from a register file outside the block. The owner of that register file pulses `req` whenever it writes the PLL configuration or the clock-select word. The block then recomputes all three values from the inputs present in that cycle. After reset it runs once by itself.

The PLL result comes from one of four modes: off, bypass (reference passed through), programmed fields, or a strap-selected table. Variant A and variant B use different bit layouts and formulas for this. The divisions run on one shared restoring divider that produces one quotient bit per cycle, so the block stays small. A single state machine steps through the work in this order: ST_LOAD captures the inputs and picks the mode. ST_FIELD_DIV waits on the first field division. ST_POST_DIV runs the second division, which only variant B needs. ST_BUS_GO starts the bus division and ST_BUS_WAIT waits for it. ST_IDLE holds the committed results.

The transitions are these. Reset enters ST_LOAD. ST_LOAD goes to ST_FIELD_DIV in programmed-field mode and to ST_BUS_GO in every other mode. ST_FIELD_DIV goes to ST_POST_DIV for variant B and to ST_BUS_GO for variant A. ST_POST_DIV goes to ST_BUS_GO. ST_BUS_GO goes to ST_BUS_WAIT, and ST_BUS_WAIT goes to ST_IDLE. A `req` in any state goes to ST_LOAD.

Top module: `pllfreq_calc`

## Requirements
- R1: `ref_hz` is 25,000,000 when `strap_ref25` is 1. Otherwise it is 48,000,000 when `strap_ref48` is 1. Otherwise it is 24,000,000.
- R2: With `variant_b`=0 and `pll_cfg` bit 17 set, `pll_hz` is 0 whatever the other bits are. With `variant_b`=1 and bit 19 set, `pll_hz` is also 0.
- R3: With `variant_b`=0, bit 17 clear and bit 19 clear, `pll_hz` is a table entry in MHz times 1,000,000. The entry is chosen by `strap_pll_sel` values 0,1,2,3. When `strap_ref25`=0 the entries are 384,360,336,408. When `strap_ref25`=1 they are 400,375,350,425.
- R4: With `variant_b`=0, bit 17 clear and bit 19 set, `pll_hz` is `ref_hz` when bit 18 is set. Otherwise it is `ref_hz`*(2-OD)*floor((N+2)/(D+1)), where N=`pll_cfg`[10:5], OD=[4] and D=[3:0].
- R5: With `variant_b`=1 and bit 19 clear, `pll_hz` is `ref_hz` when bit 20 is set. Otherwise it is `ref_hz`*floor(floor((M+1)/(N+1))/(P+1)), where P=`pll_cfg`[18:13], M=[12:5] and N=[4:0].
- R6: Products that exceed 32 bits keep their low 32 bits.
- R7: `bus_hz` is floor(floor(`pll_hz`/(S+1))/K), where S=`clk_sel`[25:23], K=2 for variant A and K=4 for variant B.
- R8: After reset `busy`=1, `valid`=0 and the outputs are 0. The block then computes from the inputs present without any request and ends with `valid`=1.
- R9: A `req` pulse in any state gives `busy`=1 and `valid`=0 on the next cycle. The committed results then reflect the inputs of the last request, even if that request cut short a calculation in progress.
- R10: `busy` and `valid` are never both 1. While `valid`=1 and no `req` arrives, the outputs hold even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Recompute request, one cycle |
| variant_b | input | 1 | 0 selects variant A, 1 selects variant B |
| strap_ref25 | input | 1 | Strap: 25 MHz reference |
| strap_ref48 | input | 1 | Strap: 48 MHz reference |
| strap_pll_sel | input | 2 | Strap: PLL table index (variant A) |
| pll_cfg | input | 32 | PLL configuration word |
| clk_sel | input | 32 | Clock-select word |
| busy | output | 1 | Calculation in progress |
| valid | output | 1 | Results committed and current |
| ref_hz | output | 32 | Reference clock in Hz |
| pll_hz | output | 32 | PLL output in Hz |
| bus_hz | output | 32 | Peripheral bus clock in Hz |

## Verification
The hardest case to reach from the ports is a request that lands in the middle of a division, while the divider still holds operands from the earlier request. The bench starts a variant-A field calculation and waits a few cycles, so the shared divider is mid-run. It then switches every input to a variant-B setting and pulses `req` again. The committed values must match the second setting. A second hard case is an input change with no request while idle, which must not be seen. The bench changes every input, waits, and compares the outputs against the values held before the change.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_FIELD_DIV,
        ST_POST_DIV,
        ST_BUS_GO,
        ST_BUS_WAIT,
        ST_IDLE
    } calc_state_t;

    typedef enum logic [1:0] {
        PM_OFF,
        PM_STRAP,
        PM_REF,
        PM_FIELD
    } pll_mode_t;

    localparam int CFG_W = 32;

    // variant A control bits and fields
    localparam int A_OFF_BIT = 17;
    localparam int A_BYP_BIT = 18;
    localparam int A_PRG_BIT = 19;
    localparam int A_N_LSB   = 5;
    localparam int A_N_W     = 6;
    localparam int A_OD_BIT  = 4;
    localparam int A_D_LSB   = 0;
    localparam int A_D_W     = 4;

    // variant B control bits and fields
    localparam int B_OFF_BIT = 19;
    localparam int B_BYP_BIT = 20;
    localparam int B_P_LSB   = 13;
    localparam int B_P_W     = 6;
    localparam int B_M_LSB   = 5;
    localparam int B_M_W     = 8;
    localparam int B_N_LSB   = 0;
    localparam int B_N_W     = 5;

    // bus divider field in the clock-select word
    localparam int PDIV_LSB  = 23;
    localparam int PDIV_W    = 3;

    function automatic pll_mode_t decode_mode(input logic is_b, input logic [CFG_W-1:0] cfg);
        pll_mode_t m;
        if (is_b) begin
            if (cfg[B_OFF_BIT])      m = PM_OFF;
            else if (cfg[B_BYP_BIT]) m = PM_REF;
            else                     m = PM_FIELD;
        end else begin
            if (cfg[A_OFF_BIT])      m = PM_OFF;
            else if (!cfg[A_PRG_BIT]) m = PM_STRAP;
            else if (cfg[A_BYP_BIT]) m = PM_REF;
            else                     m = PM_FIELD;
        end
        return m;
    endfunction

endpackage

// File: rtl/pfc_ref_decode.sv
module pfc_ref_decode #(
    parameter int FREQ_W = 32
) (
    input  logic              sel25,
    input  logic              sel48,
    input  logic [1:0]        tbl_sel,
    output logic [FREQ_W-1:0] ref_hz,
    output logic [FREQ_W-1:0] tbl_hz
);

    localparam logic [FREQ_W-1:0] HZ_25M = FREQ_W'(25_000_000);
    localparam logic [FREQ_W-1:0] HZ_48M = FREQ_W'(48_000_000);
    localparam logic [FREQ_W-1:0] HZ_24M = FREQ_W'(24_000_000);
    localparam logic [FREQ_W-1:0] ONE_MHZ = FREQ_W'(1_000_000);

    logic [9:0] tbl_mhz;

    always_comb begin
        if (sel25)      ref_hz = HZ_25M;
        else if (sel48) ref_hz = HZ_48M;
        else            ref_hz = HZ_24M;
    end

    always_comb begin
        unique case ({sel25, tbl_sel})
            3'b000:  tbl_mhz = 10'd384;
            3'b001:  tbl_mhz = 10'd360;
            3'b010:  tbl_mhz = 10'd336;
            3'b011:  tbl_mhz = 10'd408;
            3'b100:  tbl_mhz = 10'd400;
            3'b101:  tbl_mhz = 10'd375;
            3'b110:  tbl_mhz = 10'd350;
            default: tbl_mhz = 10'd425;
        endcase
        tbl_hz = FREQ_W'(tbl_mhz) * ONE_MHZ;
    end

endmodule

// File: rtl/pfc_seq_div.sv
module pfc_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quot
);

    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] STEPS = CNT_W'(W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    logic [W:0]       rem_sh;
    logic             fits;
    logic [W:0]       rem_nx;

    always_comb begin
        rem_sh = {rem_q, quo_q[W-1]};
        fits   = (rem_sh >= {1'b0, den_q});
        rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            rem_q <= '0;
            quo_q <= num;
            den_q <= den;
            cnt_q <= STEPS;
            run_q <= 1'b1;
            done  <= 1'b0;
        end else if (run_q) begin
            rem_q <= rem_nx[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - LAST;
            if (cnt_q == LAST) begin
                run_q <= 1'b0;
                done  <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign quot = quo_q;

endmodule

// File: rtl/pllfreq_calc.sv
module pllfreq_calc
    import pfc_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              variant_b,
    input  logic              strap_ref25,
    input  logic              strap_ref48,
    input  logic [1:0]        strap_pll_sel,
    input  logic [31:0]       pll_cfg,
    input  logic [31:0]       clk_sel,
    output logic              busy,
    output logic              valid,
    output logic [FREQ_W-1:0] ref_hz,
    output logic [FREQ_W-1:0] pll_hz,
    output logic [FREQ_W-1:0] bus_hz
);

    localparam logic [FREQ_W-1:0] ONE = FREQ_W'(1);
    localparam logic [FREQ_W-1:0] TWO = FREQ_W'(2);

    calc_state_t       state_q, state_d;
    pll_mode_t         mode_live;

    logic              var_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [31:0]       sel_q;
    logic [FREQ_W-1:0] ref_w;
    logic [FREQ_W-1:0] pll_w;

    logic [FREQ_W-1:0] ref_live;
    logic [FREQ_W-1:0] tbl_live;

    logic              dv_go;
    logic [FREQ_W-1:0] dv_num;
    logic [FREQ_W-1:0] dv_den;
    logic              dv_done;
    logic [FREQ_W-1:0] dv_quot;

    pfc_ref_decode #(.FREQ_W(FREQ_W)) u_ref (
        .sel25   (strap_ref25),
        .sel48   (strap_ref48),
        .tbl_sel (strap_pll_sel),
        .ref_hz  (ref_live),
        .tbl_hz  (tbl_live)
    );

    pfc_seq_div #(.W(FREQ_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dv_go),
        .num   (dv_num),
        .den   (dv_den),
        .done  (dv_done),
        .quot  (dv_quot)
    );

    assign mode_live = decode_mode(variant_b, pll_cfg);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // next state and divider control
    always_comb begin
        state_d = state_q;
        dv_go   = 1'b0;
        dv_num  = '0;
        dv_den  = '0;
        if (req) begin
            state_d = ST_LOAD;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    if (mode_live == PM_FIELD) begin
                        dv_go = 1'b1;
                        if (variant_b) begin
                            dv_num = FREQ_W'(pll_cfg[B_M_LSB +: B_M_W]) + ONE;
                            dv_den = FREQ_W'(pll_cfg[B_N_LSB +: B_N_W]) + ONE;
                        end else begin
                            dv_num = FREQ_W'(pll_cfg[A_N_LSB +: A_N_W]) + TWO;
                            dv_den = FREQ_W'(pll_cfg[A_D_LSB +: A_D_W]) + ONE;
                        end
                        state_d = ST_FIELD_DIV;
                    end else begin
                        state_d = ST_BUS_GO;
                    end
                end
                ST_FIELD_DIV: begin
                    if (dv_done) begin
                        if (var_q) begin
                            dv_go   = 1'b1;
                            dv_num  = dv_quot;
                            dv_den  = FREQ_W'(cfg_q[B_P_LSB +: B_P_W]) + ONE;
                            state_d = ST_POST_DIV;
                        end else begin
                            state_d = ST_BUS_GO;
                        end
                    end
                end
                ST_POST_DIV: begin
                    if (dv_done) state_d = ST_BUS_GO;
                end
                ST_BUS_GO: begin
                    dv_go   = 1'b1;
                    dv_num  = pll_w;
                    dv_den  = FREQ_W'(sel_q[PDIV_LSB +: PDIV_W]) + ONE;
                    state_d = ST_BUS_WAIT;
                end
                ST_BUS_WAIT: begin
                    if (dv_done) state_d = ST_IDLE;
                end
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                default: state_d = ST_LOAD;
            endcase
        end
    end

    // datapath and committed outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            var_q  <= 1'b0;
            cfg_q  <= '0;
            sel_q  <= '0;
            ref_w  <= '0;
            pll_w  <= '0;
            ref_hz <= '0;
            pll_hz <= '0;
            bus_hz <= '0;
        end else if (!req) begin
            case (state_q)
                ST_LOAD: begin
                    var_q <= variant_b;
                    cfg_q <= pll_cfg;
                    sel_q <= clk_sel;
                    ref_w <= ref_live;
                    case (mode_live)
                        PM_OFF:   pll_w <= '0;
                        PM_STRAP: pll_w <= tbl_live;
                        PM_REF:   pll_w <= ref_live;
                        default:  pll_w <= pll_w;
                    endcase
                end
                ST_FIELD_DIV: begin
                    if (dv_done && !var_q)
                        pll_w <= ref_w * (cfg_q[A_OD_BIT] ? dv_quot : (dv_quot << 1));
                end
                ST_POST_DIV: begin
                    if (dv_done) pll_w <= ref_w * dv_quot;
                end
                ST_BUS_WAIT: begin
                    if (dv_done) begin
                        ref_hz <= ref_w;
                        pll_hz <= pll_w;
                        bus_hz <= var_q ? (dv_quot >> 2) : (dv_quot >> 1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy  = (state_q != ST_IDLE);
        valid = (state_q == ST_IDLE);
    end

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              busy,
    input logic              valid,
    input logic [FREQ_W-1:0] ref_hz,
    input logic [FREQ_W-1:0] pll_hz,
    input logic [FREQ_W-1:0] bus_hz
);

    a_r10_busy_valid_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && valid));

    a_r9_req_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (busy && !valid));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !req) |=> ($stable(ref_hz) && $stable(pll_hz) && $stable(bus_hz) && valid));

    a_r7_bus_not_above_pll: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (bus_hz <= pll_hz));

    a_r1_ref_legal: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (ref_hz == FREQ_W'(25_000_000) || ref_hz == FREQ_W'(48_000_000)
                   || ref_hz == FREQ_W'(24_000_000)));

    a_r2_off_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && pll_hz == '0) |-> (bus_hz == '0));

endmodule

bind pllfreq_calc pfc_checker #(.FREQ_W(FREQ_W)) u_pfc_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .busy   (busy),
    .valid  (valid),
    .ref_hz (ref_hz),
    .pll_hz (pll_hz),
    .bus_hz (bus_hz)
);

// File: tb/pllfreq_calc_tb_top.sv
module pllfreq_calc_tb_top;

    logic        clk;
    logic        rst_n;
    logic        req;
    logic        variant_b;
    logic        strap_ref25;
    logic        strap_ref48;
    logic [1:0]  strap_pll_sel;
    logic [31:0] pll_cfg;
    logic [31:0] clk_sel;
    logic        busy;
    logic        valid;
    logic [31:0] ref_hz;
    logic [31:0] pll_hz;
    logic [31:0] bus_hz;

    int checks = 0;
    int errors = 0;

    pllfreq_calc #(.FREQ_W(32)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .variant_b     (variant_b),
        .strap_ref25   (strap_ref25),
        .strap_ref48   (strap_ref48),
        .strap_pll_sel (strap_pll_sel),
        .pll_cfg       (pll_cfg),
        .clk_sel       (clk_sel),
        .busy          (busy),
        .valid         (valid),
        .ref_hz        (ref_hz),
        .pll_hz        (pll_hz),
        .bus_hz        (bus_hz)
    );

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    function automatic logic [31:0] e_ref(bit r25, bit r48);
        if (r25) return 32'd25_000_000;
        if (r48) return 32'd48_000_000;
        return 32'd24_000_000;
    endfunction

    function automatic logic [31:0] e_pll(bit vb, logic [31:0] cfg, bit r25, bit r48, logic [1:0] ps);
        longint unsigned rf, m, a, b, c;
        rf = longint'(e_ref(r25, r48));
        if (!vb) begin
            if (cfg[17]) return 32'd0;
            if (cfg[19]) begin
                if (cfg[18]) return 32'(rf);
                a = longint'(cfg[10:5]) + 2;
                b = longint'(cfg[3:0]) + 1;
                m = (cfg[4] ? 1 : 2) * (a / b);
                return 32'(rf * m);
            end
            case ({r25, ps})
                3'b000: m = 384;
                3'b001: m = 360;
                3'b010: m = 336;
                3'b011: m = 408;
                3'b100: m = 400;
                3'b101: m = 375;
                3'b110: m = 350;
                default: m = 425;
            endcase
            return 32'(m * 1000000);
        end
        if (cfg[19]) return 32'd0;
        if (cfg[20]) return 32'(rf);
        a = longint'(cfg[12:5]) + 1;
        b = longint'(cfg[4:0]) + 1;
        c = longint'(cfg[18:13]) + 1;
        m = (a / b) / c;
        return 32'(rf * m);
    endfunction

    function automatic logic [31:0] e_bus(bit vb, logic [31:0] pll, logic [31:0] cs);
        longint unsigned q;
        q = longint'(pll) / (longint'(cs[25:23]) + 1);
        return 32'(q / (vb ? 4 : 2));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_valid();
        while (valid !== 1'b1) @(negedge clk);
    endtask

    task automatic launch(bit vb, logic [31:0] cfg, logic [31:0] cs, bit r25, bit r48, logic [1:0] ps);
        @(negedge clk);
        variant_b     = vb;
        pll_cfg       = cfg;
        clk_sel       = cs;
        strap_ref25   = r25;
        strap_ref48   = r48;
        strap_pll_sel = ps;
        req           = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic run_case(string tag, bit vb, logic [31:0] cfg, logic [31:0] cs,
                            bit r25, bit r48, logic [1:0] ps);
        logic [31:0] ep;
        launch(vb, cfg, cs, r25, r48, ps);
        chk("R9 busy after req", {31'd0, busy}, 32'd1);
        wait_valid();
        ep = e_pll(vb, cfg, r25, r48, ps);
        chk({tag, " R1 ref"}, ref_hz, e_ref(r25, r48));
        chk({tag, " pll"}, pll_hz, ep);
        chk({tag, " R7 bus"}, bus_hz, e_bus(vb, ep, cs));
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] ep;
        logic [31:0] h_ref, h_pll, h_bus;
        rst_n         = 1'b0;
        req           = 1'b0;
        variant_b     = 1'b1;
        strap_ref25   = 1'b0;
        strap_ref48   = 1'b1;
        strap_pll_sel = 2'd0;
        pll_cfg       = 32'h0000_0400 | (32'd3 << 13);
        clk_sel       = 32'd2 << 23;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state and automatic first computation
        chk("R8 busy at reset", {31'd0, busy}, 32'd1);
        chk("R8 valid at reset", {31'd0, valid}, 32'd0);
        chk("R8 pll zero at reset", pll_hz, 32'd0);
        wait_valid();
        ep = e_pll(1'b1, pll_cfg, 1'b0, 1'b1, 2'd0);
        chk("R8 first pll", pll_hz, ep);
        chk("R8 first bus", bus_hz, e_bus(1'b1, ep, clk_sel));
        chk("R8 first ref", ref_hz, 32'd48_000_000);

        // R1 and R3: strap table sweep
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++)
                run_case("R3 table", 1'b0, 32'h0, 32'h0, s[1], s[0], 2'(p));

        // R2: off dominates, both variants
        run_case("R2 off A", 1'b0, (32'd1 << 17) | (32'd1 << 19) | 32'h7FF, 32'h0, 1'b0, 1'b0, 2'd1);
        run_case("R2 off A strap", 1'b0, 32'd1 << 17, 32'd5 << 23, 1'b1, 1'b0, 2'd3);
        run_case("R2 off B", 1'b1, (32'd1 << 19) | (32'd1 << 20) | 32'h1FFF, 32'h0, 1'b1, 1'b0, 2'd0);

        // R4: variant A bypass and programmed fields
        run_case("R4 bypass", 1'b0, (32'd1 << 19) | (32'd1 << 18) | 32'h3FF, 32'd1 << 23, 1'b0, 1'b1, 2'd2);
        for (int ni = 0; ni < 5; ni++)
            for (int od = 0; od < 2; od++)
                for (int di = 0; di < 4; di++) begin
                    int nv, dv;
                    nv = (ni == 0) ? 0 : (ni == 1) ? 1 : (ni == 2) ? 7 : (ni == 3) ? 30 : 63;
                    dv = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 3 : 15;
                    run_case("R4 field", 1'b0,
                             (32'd1 << 19) | (32'(nv) << 5) | (32'(od) << 4) | 32'(dv),
                             32'(di) << 23, 1'b0, 1'b0, 2'd0);
                end

        // R6: 48 MHz * 2 * 65 wraps at 32 bits
        run_case("R6 wrap A", 1'b0, (32'd1 << 19) | (32'd63 << 5), 32'h0, 1'b0, 1'b1, 2'd0);
        run_case("R6 wrap B", 1'b1, 32'd255 << 5, 32'h0, 1'b0, 1'b1, 2'd0);

        // R5: variant B bypass and programmed fields
        run_case("R5 bypass", 1'b1, (32'd1 << 20) | 32'h1FFFF, 32'd7 << 23, 1'b1, 1'b0, 2'd0);
        for (int mi = 0; mi < 4; mi++)
            for (int nn = 0; nn < 3; nn++)
                for (int pi = 0; pi < 3; pi++) begin
                    int mv, nv, pv;
                    mv = (mi == 0) ? 0 : (mi == 1) ? 5 : (mi == 2) ? 100 : 255;
                    nv = (nn == 0) ? 0 : (nn == 1) ? 3 : 31;
                    pv = (pi == 0) ? 0 : (pi == 1) ? 2 : 63;
                    run_case("R5 field", 1'b1,
                             (32'(pv) << 13) | (32'(mv) << 5) | 32'(nv),
                             32'(mi + nn) << 23, 1'b0, 1'b0, 2'd0);
                end

        // R7: every bus divider value, both variants
        for (int d = 0; d < 8; d++) begin
            run_case("R7 div A", 1'b0, 32'h0, 32'(d) << 23, 1'b1, 1'b0, 2'd3);
            run_case("R7 div B", 1'b1, (32'd1 << 20), (32'(d) << 23) | 32'h007F_FFFF, 1'b0, 1'b1, 2'd0);
        end

        // R9: restart in the middle of a division
        launch(1'b0, (32'd1 << 19) | (32'd20 << 5) | 32'd2, 32'd3 << 23, 1'b0, 1'b0, 2'd0);
        repeat (5) @(negedge clk);
        chk("R9 still busy mid divide", {31'd0, busy}, 32'd1);
        launch(1'b1, (32'd1 << 13) | (32'd99 << 5) | 32'd4, 32'd1 << 23, 1'b1, 1'b0, 2'd2);
        chk("R9 valid low after restart", {31'd0, valid}, 32'd0);
        wait_valid();
        ep = e_pll(1'b1, (32'd1 << 13) | (32'd99 << 5) | 32'd4, 1'b1, 1'b0, 2'd2);
        chk("R9 restart pll", pll_hz, ep);
        chk("R9 restart bus", bus_hz, e_bus(1'b1, ep, 32'd1 << 23));
        chk("R9 restart ref", ref_hz, 32'd25_000_000);

        // R10: inputs change without a request while idle
        h_ref = ref_hz;
        h_pll = pll_hz;
        h_bus = bus_hz;
        @(negedge clk);
        variant_b     = 1'b0;
        pll_cfg       = 32'd1 << 17;
        clk_sel       = 32'd7 << 23;
        strap_ref25   = 1'b0;
        strap_ref48   = 1'b0;
        strap_pll_sel = 2'd1;
        repeat (40) @(negedge clk);
        chk("R10 ref held", ref_hz, h_ref);
        chk("R10 pll held", pll_hz, h_pll);
        chk("R10 bus held", bus_hz, h_bus);
        chk("R10 valid held", {31'd0, valid}, 32'd1);
        chk("R10 busy low", {31'd0, busy}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule